// File: doc/BRIEF.md
# Clean-Only Prefetch Line Buffer

This block is a small two-way set-associative store that sits inside a memory controller. It holds whole lines that a prefetch engine has already brought in from DRAM, so that a later processor read of the same line can be answered without waiting on DRAM. Lines enter only through the fill port, which carries a line returning from a prefetch. The processor read path uses the lookup port, which reports hit or miss together with the full line one cycle later.

Because the buffer is only ever read by the processor, it never holds modified data. A processor write seen on the snoop port simply removes any copy of that line, and the write data is dropped. Any line may therefore be overwritten or discarded at any time with no writeback path. A flush input empties the whole buffer at once. All indexing and tag matching use physical addresses. The default geometry is 16 sets of two ways with 128-byte lines, which is 32 lines in all.

Top module: `prefetch_line_buffer`

## Requirements
- R1: A 32-bit physical address is split as byte offset [6:0], set index [10:7] and tag [31:11]. Any byte address inside a filled line hits that line, and the same tag in a different set does not hit.
- R2: `rspValid` is high exactly in the cycle after each cycle with `lookupReq` high. With it, `rspHit` gives the result and `rspData` carries the whole stored line on a hit or all zeros on a miss.
- R3: A lookup sees the buffer contents as they were before any fill, invalidate or flush applied in that same cycle.
- R4: A fill of a line not present goes to an invalid way of its set, choosing way 0 before way 1. Two different lines of one set can therefore be held at once.
- R5: Each set has one replacement bit. A lookup hit or a fill marks the way used as most recent, and a fill into a full set replaces the least recently used way.
- R6: A fill of a line already present overwrites that way in place with the new data, and no second copy is made.
- R7: A snoop write to a held line invalidates it. A snoop write to a line not held changes nothing, and the write data is never stored.
- R8: A snoop write and a fill to the same line in the same cycle leave that line invalid.
- R9: A flush clears every valid bit in one cycle.
- R10: After reset every line is invalid and `rspValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate every line |
| lookupReq | input | 1 | Processor read lookup request |
| lookupAddr | input | 32 | Physical address of the lookup |
| fillReq | input | 1 | Prefetched line is present on the fill port |
| fillAddr | input | 32 | Physical address of the prefetched line |
| fillData | input | 1024 | Prefetched line contents |
| snoopWr | input | 1 | A processor write was seen |
| snoopAddr | input | 32 | Physical address of the write |
| rspValid | output | 1 | Lookup result is valid |
| rspHit | output | 1 | Lookup found the line |
| rspData | output | 1024 | Line on a hit, zero on a miss |

## Verification
The hardest cases to reach from the ports are those where several events act on one set in a single cycle. These are a fill racing a snoop to the same line, a fill racing a lookup, and a replacement whose victim depends on which way a lookup touched before. The stimulus first fills a set to capacity, then steers its replacement bit with a chosen lookup. It then fires a third fill, raises two ports together in one cycle, and reads back through ordinary lookups which lines survived.

// File: rtl/pfbuf_pkg.sv
package pfbuf_pkg;
  // Two ways are assumed by the single replacement bit per set.
  localparam int NUM_WAYS = 2;

  typedef struct packed {
    logic                fillWr;   // write the fill line
    logic                fillWay;  // way that receives the fill
    logic [NUM_WAYS-1:0] snpInv;   // ways of the snoop set to invalidate
    logic                lkLruWr;  // lookup hit updates replacement bit
    logic                lkLruVal; // way to evict next after that hit
    logic                flushAll; // clear all valid bits
  } ctrlT;
endpackage

// File: rtl/pfbuf_datapath.sv
module pfbuf_datapath
  import pfbuf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int NUM_SETS   = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlT                     ctrl,
  input  logic                     lookupReq,
  input  logic [ADDR_W-1:0]        lookupAddr,
  input  logic [ADDR_W-1:0]        fillAddr,
  input  logic [LINE_BYTES*8-1:0]  fillData,
  input  logic [ADDR_W-1:0]        snoopAddr,
  output logic [NUM_WAYS-1:0]      lkMatch,
  output logic [NUM_WAYS-1:0]      fillMatch,
  output logic [NUM_WAYS-1:0]      fillValid,
  output logic                     fillLru,
  output logic [NUM_WAYS-1:0]      snpMatch,
  output logic                     rspValid,
  output logic                     rspHit,
  output logic [LINE_BYTES*8-1:0]  rspData
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(NUM_SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W = LINE_BYTES * 8;

  logic [TAG_W-1:0]    tagQ   [NUM_SETS][NUM_WAYS];
  logic [LINE_W-1:0]   dataQ  [NUM_SETS][NUM_WAYS];
  logic [NUM_WAYS-1:0] validQ [NUM_SETS];
  logic [NUM_SETS-1:0] lruQ;

  logic [IDX_W-1:0] lkIdx, fillIdx, snpIdx;
  logic [TAG_W-1:0] lkTag, fillTag, snpTag;
  logic [LINE_W-1:0] hitLine;

  assign lkIdx   = lookupAddr[OFF_W +: IDX_W];
  assign fillIdx = fillAddr[OFF_W +: IDX_W];
  assign snpIdx  = snoopAddr[OFF_W +: IDX_W];
  assign lkTag   = lookupAddr[ADDR_W-1 -: TAG_W];
  assign fillTag = fillAddr[ADDR_W-1 -: TAG_W];
  assign snpTag  = snoopAddr[ADDR_W-1 -: TAG_W];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign lkMatch[w]   = validQ[lkIdx][w]   && (tagQ[lkIdx][w]   == lkTag);
    assign fillMatch[w] = validQ[fillIdx][w] && (tagQ[fillIdx][w] == fillTag);
    assign snpMatch[w]  = validQ[snpIdx][w]  && (tagQ[snpIdx][w]  == snpTag);
    assign fillValid[w] = validQ[fillIdx][w];
  end
  assign fillLru = lruQ[fillIdx];

  always_comb begin
    hitLine = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (lkMatch[w]) hitLine = hitLine | dataQ[lkIdx][w];
  end

  // Valid bits and replacement bits.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) validQ[s] <= '0;
      lruQ <= '0;
    end else begin
      if (ctrl.flushAll) begin
        for (int s = 0; s < NUM_SETS; s++) validQ[s] <= '0;
      end else begin
        for (int w = 0; w < NUM_WAYS; w++)
          if (ctrl.snpInv[w]) validQ[snpIdx][w] <= 1'b0;
        if (ctrl.fillWr) validQ[fillIdx][ctrl.fillWay] <= 1'b1;
      end
      if (ctrl.lkLruWr) lruQ[lkIdx] <= ctrl.lkLruVal;
      if (ctrl.fillWr)  lruQ[fillIdx] <= ~ctrl.fillWay;
    end
  end

  // Tag and line storage need no reset: valid bits gate them.
  always_ff @(posedge clk) begin
    if (ctrl.fillWr) begin
      tagQ[fillIdx][ctrl.fillWay]  <= fillTag;
      dataQ[fillIdx][ctrl.fillWay] <= fillData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= lookupReq;
      rspHit   <= lookupReq && (|lkMatch);
      rspData  <= lookupReq ? hitLine : '0;
    end
  end
endmodule

// File: rtl/pfbuf_control.sv
module pfbuf_control
  import pfbuf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int NUM_SETS   = 16
) (
  input  logic                flush,
  input  logic                lookupReq,
  input  logic                fillReq,
  input  logic                snoopWr,
  input  logic [ADDR_W-1:0]   fillAddr,
  input  logic [ADDR_W-1:0]   snoopAddr,
  input  logic [NUM_WAYS-1:0] lkMatch,
  input  logic [NUM_WAYS-1:0] fillMatch,
  input  logic [NUM_WAYS-1:0] fillValid,
  input  logic                fillLru,
  input  logic [NUM_WAYS-1:0] snpMatch,
  output ctrlT                ctrl
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(NUM_SETS);

  logic sameLine, sameSet, clash, wayPick;

  assign sameLine = fillAddr[ADDR_W-1:OFF_W] == snoopAddr[ADDR_W-1:OFF_W];
  assign sameSet  = fillAddr[OFF_W +: IDX_W] == snoopAddr[OFF_W +: IDX_W];
  assign clash    = fillReq && snoopWr && sameLine;

  always_comb begin
    if (|fillMatch)        wayPick = fillMatch[1];
    else if (!fillValid[0]) wayPick = 1'b0;
    else if (!fillValid[1]) wayPick = 1'b1;
    else                    wayPick = fillLru;
  end

  always_comb begin
    ctrl          = '0;
    ctrl.flushAll = flush;
    ctrl.fillWr   = fillReq && !clash && !flush;
    ctrl.fillWay  = wayPick;
    ctrl.snpInv   = snoopWr ? snpMatch : '0;
    if (ctrl.fillWr && sameSet) ctrl.snpInv[wayPick] = 1'b0;
    ctrl.lkLruWr  = lookupReq && (|lkMatch);
    ctrl.lkLruVal = lkMatch[0];
  end
endmodule

// File: rtl/prefetch_line_buffer.sv
module prefetch_line_buffer
  import pfbuf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int NUM_SETS   = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    flush,
  input  logic                    lookupReq,
  input  logic [ADDR_W-1:0]       lookupAddr,
  input  logic                    fillReq,
  input  logic [ADDR_W-1:0]       fillAddr,
  input  logic [LINE_BYTES*8-1:0] fillData,
  input  logic                    snoopWr,
  input  logic [ADDR_W-1:0]       snoopAddr,
  output logic                    rspValid,
  output logic                    rspHit,
  output logic [LINE_BYTES*8-1:0] rspData
);
  ctrlT ctrl;
  logic [NUM_WAYS-1:0] lkMatch, fillMatch, fillValid, snpMatch;
  logic fillLru;

  pfbuf_control #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .NUM_SETS(NUM_SETS)) i_control (
    .flush(flush), .lookupReq(lookupReq), .fillReq(fillReq), .snoopWr(snoopWr),
    .fillAddr(fillAddr), .snoopAddr(snoopAddr), .lkMatch(lkMatch),
    .fillMatch(fillMatch), .fillValid(fillValid), .fillLru(fillLru),
    .snpMatch(snpMatch), .ctrl(ctrl)
  );

  pfbuf_datapath #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .NUM_SETS(NUM_SETS)) i_datapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .lookupReq(lookupReq),
    .lookupAddr(lookupAddr), .fillAddr(fillAddr), .fillData(fillData),
    .snoopAddr(snoopAddr), .lkMatch(lkMatch), .fillMatch(fillMatch),
    .fillValid(fillValid), .fillLru(fillLru), .snpMatch(snpMatch),
    .rspValid(rspValid), .rspHit(rspHit), .rspData(rspData)
  );
endmodule

// File: rtl/pfbuf_chk.sv
module pfbuf_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    flush,
  input logic                    lookupReq,
  input logic [ADDR_W-1:0]       lookupAddr,
  input logic                    fillReq,
  input logic [ADDR_W-1:0]       fillAddr,
  input logic [LINE_BYTES*8-1:0] fillData,
  input logic                    snoopWr,
  input logic [ADDR_W-1:0]       snoopAddr,
  input logic                    rspValid,
  input logic                    rspHit,
  input logic [LINE_BYTES*8-1:0] rspData
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    lookupReq |=> rspValid); // R2
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !lookupReq |=> !rspValid); // R2
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> rspValid); // R2
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspData == '0)); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    flush ##1 lookupReq |=> !rspHit); // R9
  AST_SNOOP_KILLS: assert property (@(posedge clk) disable iff (!rstN)
    snoopWr ##1 (lookupReq && lookupAddr[ADDR_W-1:OFF_W] == $past(snoopAddr[ADDR_W-1:OFF_W]))
    |=> !rspHit); // R7
  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (fillReq && !flush && !(snoopWr && snoopAddr[ADDR_W-1:OFF_W] == fillAddr[ADDR_W-1:OFF_W]))
    ##1 (lookupReq && lookupAddr[ADDR_W-1:OFF_W] == $past(fillAddr[ADDR_W-1:OFF_W]))
    |=> (rspHit && rspData == $past(fillData, 2))); // R6
endmodule

bind prefetch_line_buffer pfbuf_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) i_pfbuf_chk (
  .clk(clk), .rstN(rstN), .flush(flush), .lookupReq(lookupReq), .lookupAddr(lookupAddr),
  .fillReq(fillReq), .fillAddr(fillAddr), .fillData(fillData), .snoopWr(snoopWr),
  .snoopAddr(snoopAddr), .rspValid(rspValid), .rspHit(rspHit), .rspData(rspData)
);

// File: tb/test_prefetch_line_buffer.sv
module test_prefetch_line_buffer;
  localparam int LINE_W = 1024;
  localparam logic [1:0] OP_FILL = 2'd0, OP_LOOK = 2'd1, OP_SNOOP = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] addr;
    logic [7:0]  seed;
    logic        expHit;
    logic [7:0]  rq;
  } vecT;

  // set 3: A tag1 = 0x980, B tag2 = 0x1180, C tag3 = 0x1980, tag9 = 0x4980
  localparam vecT VEC [17] = '{
    '{OP_FILL,  32'h0000_0980, 8'd1, 1'b0, 8'd4},  // R4 A -> way 0
    '{OP_LOOK,  32'h0000_09C5, 8'd1, 1'b1, 8'd1},  // R1 offset inside line
    '{OP_LOOK,  32'h0000_0A00, 8'd0, 1'b0, 8'd1},  // R1 same tag, set 4
    '{OP_FILL,  32'h0000_1180, 8'd2, 1'b0, 8'd4},  // R4 B -> way 1
    '{OP_LOOK,  32'h0000_0980, 8'd1, 1'b1, 8'd4},  // R4 A kept
    '{OP_LOOK,  32'h0000_1180, 8'd2, 1'b1, 8'd4},  // R4 B, A now LRU
    '{OP_FILL,  32'h0000_1980, 8'd3, 1'b0, 8'd5},  // R5 C evicts A
    '{OP_LOOK,  32'h0000_0980, 8'd0, 1'b0, 8'd5},  // R5
    '{OP_LOOK,  32'h0000_1180, 8'd2, 1'b1, 8'd5},  // R5
    '{OP_LOOK,  32'h0000_1980, 8'd3, 1'b1, 8'd5},  // R5
    '{OP_SNOOP, 32'h0000_1188, 8'd0, 1'b0, 8'd7},  // R7 write to B
    '{OP_LOOK,  32'h0000_1180, 8'd0, 1'b0, 8'd7},  // R7
    '{OP_LOOK,  32'h0000_1980, 8'd3, 1'b1, 8'd7},  // R7 C untouched
    '{OP_SNOOP, 32'h0000_4980, 8'd0, 1'b0, 8'd7},  // R7 line not held
    '{OP_LOOK,  32'h0000_1980, 8'd3, 1'b1, 8'd7},  // R7
    '{OP_FILL,  32'h0000_1980, 8'd4, 1'b0, 8'd6},  // R6 refill C
    '{OP_LOOK,  32'h0000_1980, 8'd4, 1'b1, 8'd6}   // R6 new data
  };

  logic clk = 1'b0, rstN = 1'b0, flush = 1'b0;
  logic lookupReq = 1'b0, fillReq = 1'b0, snoopWr = 1'b0;
  logic [31:0] lookupAddr = '0, fillAddr = '0, snoopAddr = '0;
  logic [LINE_W-1:0] fillData = '0;
  logic rspValid, rspHit;
  logic [LINE_W-1:0] rspData;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  prefetch_line_buffer i_prefetch_line_buffer (
    .clk(clk), .rstN(rstN), .flush(flush), .lookupReq(lookupReq), .lookupAddr(lookupAddr),
    .fillReq(fillReq), .fillAddr(fillAddr), .fillData(fillData), .snoopWr(snoopWr),
    .snoopAddr(snoopAddr), .rspValid(rspValid), .rspHit(rspHit), .rspData(rspData)
  );

  function automatic logic [LINE_W-1:0] lineOf(input logic [7:0] s);
    logic [LINE_W-1:0] r;
    for (int i = 0; i < LINE_W / 32; i++) r[i*32 +: 32] = {s, 8'h5A, 8'(i), s ^ 8'(i)};
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    lookupReq = 0; fillReq = 0; snoopWr = 0; flush = 0;
  endtask

  task automatic doFill(input logic [31:0] a, input logic [7:0] s);
    @(negedge clk); fillReq = 1; fillAddr = a; fillData = lineOf(s);
    idle();
  endtask

  task automatic doSnoop(input logic [31:0] a);
    @(negedge clk); snoopWr = 1; snoopAddr = a;
    idle();
  endtask

  // Lookup issued at a negedge; result registered at the next posedge, read at the following negedge.
  task automatic doLook(input string req, input logic [31:0] a, input logic expHit,
                        input logic [7:0] s);
    @(negedge clk); lookupReq = 1; lookupAddr = a;
    idle();
    check(req, {31'd0, rspValid}, 32'd1);
    check(req, {31'd0, rspHit}, {31'd0, expHit});
    checks++;
    if (rspData !== (expHit ? lineOf(s) : '0)) begin
      failures++;
      $display("FAIL %s data actual=%h expected=%h", req, rspData[31:0],
               expHit ? lineOf(s) : '0);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R10: reset state
    check("R10 rspValid", {31'd0, rspValid}, 32'd0);
    doLook("R10", 32'h0000_0980, 1'b0, 8'd0);
    // R2: no response without request
    idle();
    check("R2 idle", {31'd0, rspValid}, 32'd0);

    for (int k = 0; k < 17; k++) begin
      case (VEC[k].op)
        OP_FILL:  doFill(VEC[k].addr, VEC[k].seed);
        OP_SNOOP: doSnoop(VEC[k].addr);
        default:  doLook($sformatf("R%0d vec%0d", VEC[k].rq, k), VEC[k].addr,
                         VEC[k].expHit, VEC[k].seed);
      endcase
    end

    // R3: lookup in same cycle as fill sees old contents
    @(negedge clk); fillReq = 1; fillAddr = 32'h0000_2280; fillData = lineOf(8'd7);
    lookupReq = 1; lookupAddr = 32'h0000_2280;
    idle();
    check("R3 same-cycle miss", {31'd0, rspHit}, 32'd0);
    doLook("R3 later hit", 32'h0000_2280, 1'b1, 8'd7);

    // R8: fill and snoop of one line together leave it invalid
    @(negedge clk); fillReq = 1; fillAddr = 32'h0000_3300; fillData = lineOf(8'd8);
    snoopWr = 1; snoopAddr = 32'h0000_3340;
    idle();
    doLook("R8 clash", 32'h0000_3300, 1'b0, 8'd0);
    // R8 present line: refill and snoop together invalidate it
    @(negedge clk); fillReq = 1; fillAddr = 32'h0000_2280; fillData = lineOf(8'd9);
    snoopWr = 1; snoopAddr = 32'h0000_2280;
    idle();
    doLook("R8 held clash", 32'h0000_2280, 1'b0, 8'd0);

    // R4: invalid way reused before evicting (set 3 holds C, one way free after snoop)
    doFill(32'h0000_4980, 8'd10);
    doLook("R4 reuse free way", 32'h0000_4980, 1'b1, 8'd10);
    doLook("R4 C still held", 32'h0000_1980, 1'b1, 8'd4);

    // R9: flush empties everything
    doFill(32'h0000_0380, 8'd11);
    @(negedge clk); flush = 1;
    idle();
    doLook("R9 set 7", 32'h0000_0380, 1'b0, 8'd0);
    doLook("R9 set 3", 32'h0000_1980, 1'b0, 8'd0);
    doLook("R9 set 3 way", 32'h0000_4980, 1'b0, 8'd0);

    finishRun();
  end
endmodule